// File: doc/BRIEF.md
# System management command decoder

This block sits behind the byte-write path of an SMBus slave. Each time the slave engine delivers a command-type byte together with a one-cycle valid strobe, the decoder turns that byte into system-management actions. The actions are wake and SMI requests, a power-down event, two flavours of hard reset, and a watchdog reload pulse. The decoder also keeps a small set of sticky status bits and a latch that silences heartbeat and event messages.

What a command does depends on the platform power state. The wake command becomes either a wake request or an SMI, depending on whether the system is already awake. The slave-SMI status bit only latches while the system is in the working state. The message-silence latch belongs to the resume well, so only the resume-well reset can clear it.

Every valid byte is acknowledged, even when it causes no action. Because of this, the bit-level engine upstream never waits on the decoder. All action outputs are single-cycle pulses that appear on the cycle after the valid strobe.

Top module: `smb_mgmt_decoder`

## Requirements
- R1: Every cycle with `cmd_valid` high produces exactly one `cmd_ack` pulse on the following cycle, whatever the byte value or power state. `cmd_ack` is never high without a valid strobe one cycle earlier.
- R2: Command values 0, 7 and 9 through 255 are reserved. They raise no action pulse and change no status bit or latch.
- R3: Command 1 with `sys_awake` low pulses `wake_req`. With `sys_awake` high it pulses `smi_req` instead. The two are never high together.
- R4: Command 1 sets `wake_sts` whether or not the system is awake. `wake_sts` stays set until a `wake_sts_clr` strobe arrives. A set in the same cycle as a clear wins.
- R5: Command 2 sets `pwrbtn_sts` and pulses `pwr_down`. `pwrbtn_sts` clears on `pwrbtn_sts_clr`, and a set in the same cycle as a clear wins.
- R6: Command 3 pulses `hard_rst` with `rst_code` = 4'b0110 (bits 2:1 set, bit 3 clear). Command 4 pulses `hard_rst` with `rst_code` = 4'b1110 (bits 3:1 set). `rst_code` is 0 whenever `hard_rst` is low.
- R7: Command 5 sets `msg_disable`. No clear strobe affects it. Only driving `rsm_rst_n` low and then high again clears it.
- R8: Command 6 produces a single-cycle `wdt_reload` pulse.
- R9: Command 8 sets `slv_smi_sts` only when `in_s0` is high. When `in_s0` is low, the command is acknowledged and the bit keeps its value. `slv_smi_sts` clears on `slv_smi_sts_clr`.
- R10: While `rsm_rst_n` is low, every output is 0.
- R11: Each action pulse (`wake_req`, `smi_req`, `pwr_down`, `hard_rst`, `wdt_reload`, `cmd_ack`) lasts one cycle unless another command asks for it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rsm_rst_n | input | 1 | Resume-well reset, active low, asynchronous assert |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_byte` holds a new command |
| cmd_byte | input | CMD_W | Command-type byte |
| in_s0 | input | 1 | System is in the working state |
| sys_awake | input | 1 | System is already awake |
| wake_sts_clr | input | 1 | Write-one-to-clear strobe for `wake_sts` |
| pwrbtn_sts_clr | input | 1 | Write-one-to-clear strobe for `pwrbtn_sts` |
| slv_smi_sts_clr | input | 1 | Write-one-to-clear strobe for `slv_smi_sts` |
| cmd_ack | output | 1 | Acknowledge pulse |
| wake_req | output | 1 | Wake request pulse |
| smi_req | output | 1 | SMI request pulse |
| pwr_down | output | 1 | Unconditional power-down pulse |
| hard_rst | output | 1 | Hard reset request pulse |
| rst_code | output | 4 | Reset-control code that accompanies `hard_rst` |
| wdt_reload | output | 1 | Watchdog reload pulse |
| wake_sts | output | 1 | Sticky wake status |
| pwrbtn_sts | output | 1 | Sticky power-button-override status |
| slv_smi_sts | output | 1 | Sticky slave-SMI status |
| msg_disable | output | 1 | Heartbeat/event message suppression latch |

## Verification
The assertions check the following on every cycle:
- the acknowledge pulse follows each valid strobe and never appears without one;
- the wake and SMI requests are mutually exclusive;
- reserved bytes cause no action;
- the reset code has its fixed pattern;
- wake status and the message latch hold their value;
- the slave-SMI bit stays unchanged outside S0;
- the reload pulse is single-cycle.

The directed scenarios are needed for the rest:
- the exact action chosen by each command value;
- set-over-clear priority at the status bits;
- the message latch surviving every software clear strobe;
- the latch clearing only across a full resume-reset cycle.

// File: rtl/smb_mgmt_decoder.sv
module smb_mgmt_decoder #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rsm_rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             in_s0,
  input  logic             sys_awake,
  input  logic             wake_sts_clr,
  input  logic             pwrbtn_sts_clr,
  input  logic             slv_smi_sts_clr,
  output logic             cmd_ack,
  output logic             wake_req,
  output logic             smi_req,
  output logic             pwr_down,
  output logic             hard_rst,
  output logic [3:0]       rst_code,
  output logic             wdt_reload,
  output logic             wake_sts,
  output logic             pwrbtn_sts,
  output logic             slv_smi_sts,
  output logic             msg_disable
);

  localparam logic [CMD_W-1:0] C_WAKE   = CMD_W'(1);
  localparam logic [CMD_W-1:0] C_PWROFF = CMD_W'(2);
  localparam logic [CMD_W-1:0] C_RSTWARM= CMD_W'(3);
  localparam logic [CMD_W-1:0] C_RSTCOLD= CMD_W'(4);
  localparam logic [CMD_W-1:0] C_MSGOFF = CMD_W'(5);
  localparam logic [CMD_W-1:0] C_WDT    = CMD_W'(6);
  localparam logic [CMD_W-1:0] C_SLVSMI = CMD_W'(8);
  localparam logic [3:0] CODE_WARM = 4'b0110;
  localparam logic [3:0] CODE_COLD = 4'b1110;

  logic hit_wake, hit_pwroff, hit_warm, hit_cold, hit_msgoff, hit_wdt, hit_slvsmi;
  logic reserved;

  assign hit_wake   = cmd_valid && (cmd_byte == C_WAKE);
  assign hit_pwroff = cmd_valid && (cmd_byte == C_PWROFF);
  assign hit_warm   = cmd_valid && (cmd_byte == C_RSTWARM);
  assign hit_cold   = cmd_valid && (cmd_byte == C_RSTCOLD);
  assign hit_msgoff = cmd_valid && (cmd_byte == C_MSGOFF);
  assign hit_wdt    = cmd_valid && (cmd_byte == C_WDT);
  assign hit_slvsmi = cmd_valid && (cmd_byte == C_SLVSMI);
  assign reserved   = !(hit_wake || hit_pwroff || hit_warm || hit_cold ||
                        hit_msgoff || hit_wdt || hit_slvsmi);

  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      cmd_ack    <= 1'b0;
      wake_req   <= 1'b0;
      smi_req    <= 1'b0;
      pwr_down   <= 1'b0;
      hard_rst   <= 1'b0;
      rst_code   <= 4'b0000;
      wdt_reload <= 1'b0;
    end else begin
      cmd_ack    <= cmd_valid;
      wake_req   <= hit_wake && !sys_awake;
      smi_req    <= hit_wake && sys_awake;
      pwr_down   <= hit_pwroff;
      hard_rst   <= hit_warm || hit_cold;
      rst_code   <= hit_cold ? CODE_COLD : (hit_warm ? CODE_WARM : 4'b0000);
      wdt_reload <= hit_wdt;
    end
  end

  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      wake_sts    <= 1'b0;
      pwrbtn_sts  <= 1'b0;
      slv_smi_sts <= 1'b0;
      msg_disable <= 1'b0;
    end else begin
      if (hit_wake)                  wake_sts <= 1'b1;
      else if (wake_sts_clr)         wake_sts <= 1'b0;
      if (hit_pwroff)                pwrbtn_sts <= 1'b1;
      else if (pwrbtn_sts_clr)       pwrbtn_sts <= 1'b0;
      if (hit_slvsmi && in_s0)       slv_smi_sts <= 1'b1;
      else if (slv_smi_sts_clr)      slv_smi_sts <= 1'b0;
      if (hit_msgoff)                msg_disable <= 1'b1;
    end
  end

  assert_ack_follows_valid_R1: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    cmd_valid |=> cmd_ack);
  assert_ack_needs_valid_R1: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    cmd_ack |-> $past(cmd_valid));
  assert_reserved_quiet_R2: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (cmd_valid && reserved) |=> !(wake_req || smi_req || pwr_down || hard_rst || wdt_reload));
  assert_wake_smi_exclusive_R3: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    !(wake_req && smi_req));
  assert_wake_sts_hold_R4: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (wake_sts && !wake_sts_clr) |=> wake_sts);
  assert_rst_code_shape_R6: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    hard_rst |-> (rst_code[2:0] == 3'b110));
  assert_rst_code_idle_R6: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    !hard_rst |-> (rst_code == 4'b0000));
  assert_msg_disable_sticky_R7: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    msg_disable |=> msg_disable);
  assert_slv_smi_gated_R9: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (cmd_valid && cmd_byte == C_SLVSMI && !in_s0 && !slv_smi_sts) |=> !slv_smi_sts);
  assert_reload_single_R11: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (wdt_reload && !hit_wdt) |=> !wdt_reload);

endmodule

// File: tb/tb_smb_mgmt_decoder.sv
module tb_smb_mgmt_decoder;
  logic clk = 1'b0;
  logic rsm_rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic in_s0 = 1'b1, sys_awake = 1'b1;
  logic wake_sts_clr = 1'b0, pwrbtn_sts_clr = 1'b0, slv_smi_sts_clr = 1'b0;
  logic cmd_ack, wake_req, smi_req, pwr_down, hard_rst, wdt_reload;
  logic [3:0] rst_code;
  logic wake_sts, pwrbtn_sts, slv_smi_sts, msg_disable;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  smb_mgmt_decoder #(.CMD_W(8)) dut (
    .clk(clk), .rsm_rst_n(rsm_rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .in_s0(in_s0), .sys_awake(sys_awake), .wake_sts_clr(wake_sts_clr),
    .pwrbtn_sts_clr(pwrbtn_sts_clr), .slv_smi_sts_clr(slv_smi_sts_clr),
    .cmd_ack(cmd_ack), .wake_req(wake_req), .smi_req(smi_req), .pwr_down(pwr_down),
    .hard_rst(hard_rst), .rst_code(rst_code), .wdt_reload(wdt_reload),
    .wake_sts(wake_sts), .pwrbtn_sts(pwrbtn_sts), .slv_smi_sts(slv_smi_sts),
    .msg_disable(msg_disable)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pulses();
    return {26'd0, cmd_ack, wake_req, smi_req, pwr_down, hard_rst, wdt_reload};
  endfunction

  function automatic logic [31:0] stats();
    return {28'd0, wake_sts, pwrbtn_sts, slv_smi_sts, msg_disable};
  endfunction

  task automatic send(logic [7:0] c, logic wclr = 1'b0, logic pclr = 1'b0, logic sclr = 1'b0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = c;
    wake_sts_clr = wclr; pwrbtn_sts_clr = pclr; slv_smi_sts_clr = sclr;
    @(negedge clk);
    cmd_valid = 1'b0; wake_sts_clr = 1'b0; pwrbtn_sts_clr = 1'b0; slv_smi_sts_clr = 1'b0;
  endtask

  task automatic strobe_clears(logic w, logic p, logic s);
    @(negedge clk);
    wake_sts_clr = w; pwrbtn_sts_clr = p; slv_smi_sts_clr = s;
    @(negedge clk);
    wake_sts_clr = 1'b0; pwrbtn_sts_clr = 1'b0; slv_smi_sts_clr = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R10 pulses in reset", pulses(), 0);
    check("R10 status in reset", stats(), 0);
    check("R10 rst_code in reset", {28'd0, rst_code}, 0);
    repeat (2) @(negedge clk);
    rsm_rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", pulses(), 0);
  endtask

  task automatic t_reserved();
    logic [7:0] vals [5] = '{8'h00, 8'h07, 8'h09, 8'h5A, 8'hFF};
    for (int i = 0; i < 5; i++) begin
      send(vals[i]);
      check("R2 reserved ack only (R1)", pulses(), 32'h20);
      check("R2 reserved status untouched", stats(), 0);
      check("R2 reserved rst_code", {28'd0, rst_code}, 0);
    end
    @(negedge clk);
    check("R1 ack single", {31'd0, cmd_ack}, 0);
  endtask

  task automatic t_wake();
    sys_awake = 1'b0;
    send(8'h01);
    check("R3 asleep -> wake_req", pulses(), 32'h30);
    check("R4 wake_sts set", {31'd0, wake_sts}, 1);
    @(negedge clk);
    check("R11 wake pulse one cycle", pulses(), 0);
    sys_awake = 1'b1;
    send(8'h01, 1'b1);
    check("R3 awake -> smi_req", pulses(), 32'h28);
    check("R4 set beats clear", {31'd0, wake_sts}, 1);
    strobe_clears(1'b1, 1'b0, 1'b0);
    check("R4 wake_sts cleared", {31'd0, wake_sts}, 0);
  endtask

  task automatic t_pwroff();
    send(8'h02);
    check("R5 pwr_down pulse", pulses(), 32'h24);
    check("R5 pwrbtn_sts set", {31'd0, pwrbtn_sts}, 1);
    send(8'h02, 1'b0, 1'b1);
    check("R5 set beats clear", {31'd0, pwrbtn_sts}, 1);
    strobe_clears(1'b0, 1'b1, 1'b0);
    check("R5 pwrbtn_sts cleared", {31'd0, pwrbtn_sts}, 0);
  endtask

  task automatic t_resets();
    send(8'h03);
    check("R6 warm reset pulse", pulses(), 32'h22);
    check("R6 warm code", {28'd0, rst_code}, 32'h6);
    send(8'h04);
    check("R6 cold reset pulse", pulses(), 32'h22);
    check("R6 cold code", {28'd0, rst_code}, 32'hE);
    @(negedge clk);
    check("R11 reset pulse one cycle", {31'd0, hard_rst}, 0);
    check("R6 code idle", {28'd0, rst_code}, 0);
  endtask

  task automatic t_wdt();
    send(8'h06);
    check("R8 wdt_reload pulse", pulses(), 32'h21);
    @(negedge clk);
    check("R8 wdt_reload single cycle", {31'd0, wdt_reload}, 0);
  endtask

  task automatic t_slvsmi();
    in_s0 = 1'b0;
    send(8'h08);
    check("R9 outside S0 acked", pulses(), 32'h20);
    check("R9 outside S0 bit clear", {31'd0, slv_smi_sts}, 0);
    in_s0 = 1'b1;
    send(8'h08);
    check("R9 S0 bit set", {31'd0, slv_smi_sts}, 1);
    in_s0 = 1'b0;
    send(8'h08);
    check("R9 outside S0 bit kept", {31'd0, slv_smi_sts}, 1);
    strobe_clears(1'b0, 1'b0, 1'b1);
    check("R9 bit cleared", {31'd0, slv_smi_sts}, 0);
    in_s0 = 1'b1;
  endtask

  task automatic t_msgdis();
    send(8'h05);
    check("R7 msg_disable set", {31'd0, msg_disable}, 1);
    check("R7 no action pulse", pulses(), 32'h20);
    strobe_clears(1'b1, 1'b1, 1'b1);
    check("R7 clear strobes ignored", {31'd0, msg_disable}, 1);
    @(negedge clk);
    rsm_rst_n = 1'b0;
    #1;
    check("R7 cleared by resume reset", {31'd0, msg_disable}, 0);
    @(negedge clk);
    rsm_rst_n = 1'b1;
    @(negedge clk);
    check("R7 stays clear after deassert", {31'd0, msg_disable}, 0);
  endtask

  initial begin
    t_reset();
    t_reserved();
    t_wake();
    t_pwroff();
    t_resets();
    t_wdt();
    t_slvsmi();
    t_msgdis();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule